// File: doc/BRIEF.md
# Processor Special-Cycle Dispatcher

This block sits on the request side of a split-transaction processor bus. Each request presents two request codes (one per address phase), an 8-bit byte-enable field from the second phase, and bit 7 of the second-phase address. The block picks out special-cycle requests by their request-code pair and decodes the cycle type from the byte-enable field. It then does one of three things. It retires the cycle locally. It forwards the cycle to a downstream hub port and waits for that port to end it with a master abort before retiring it. Or, for the system-management acknowledge type, it updates a sticky system-management-mode flag.

While the flag is set, any processor transaction that carries address bit 7 is tagged as an access to system-management space. Only one forwarded cycle may be outstanding at a time. While one is outstanding, a new special cycle is held off through a ready output.

Top module: `spc_dispatch`

## Requirements
- R1: A request is a special cycle only when `code_p1` is 5'b01000 and `code_p2[2:0]` is 3'b001. `code_p2[4:3]` are don't-care. A special cycle that is accepted raises `claim` in the same cycle.
- R2: The type values 0x00, 0x02, 0x04 and 0x05 on `be_p2` are retired locally. `retire` pulses for one cycle in the cycle after the claim, and no hub request is made.
- R3: The type values 0x01, 0x03 and 0x06 are forwarded. In the cycle after the claim, `hub_req_valid` pulses for one cycle, with `hub_req_type` set to 2'b00, 2'b01 and 2'b10 respectively.
- R4: A forwarded cycle is retired only by `hub_abort`. `retire` pulses in the cycle after the abort and never earlier.
- R5: While a forwarded cycle is outstanding, `txn_ready` is low for any special-cycle request, and no such request is claimed. `txn_ready` returns high in the cycle after the abort.
- R6: Type 0x07 with `addr_p2_b7`=1 sets `sys_mode` from the next cycle on. It retires in the cycle after the claim and never makes a hub request.
- R7: Type 0x07 with `addr_p2_b7`=0 clears `sys_mode` from the next cycle on, and retires the same way as under R6.
- R8: `sys_access` is high exactly when `txn_valid` is high, `sys_mode` is set and `addr_p2_b7` is 1.
- R9: Any type value above 0x07 is retired in the next cycle with no hub request and no change to `sys_mode`. It sets `rsvd_err`, which then stays set until reset.
- R10: A request that is not a special cycle produces no claim, no retire and no hub request, and it leaves `sys_mode` unchanged.
- R11: After reset, `sys_mode` and `rsvd_err` are 0, `txn_ready` is 1, and `retire` and `hub_req_valid` are 0.
- R12: A `hub_abort` pulse while nothing is outstanding produces no retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | A processor request is presented this cycle |
| code_p1 | input | 5 | First-phase request code |
| code_p2 | input | 5 | Second-phase request code |
| be_p2 | input | 8 | Second-phase byte-enable field (cycle type) |
| addr_p2_b7 | input | 1 | Second-phase address bit 7 |
| txn_ready | output | 1 | Low when a special cycle must be held off |
| claim | output | 1 | Special cycle accepted this cycle |
| retire | output | 1 | One-cycle pulse that retires a special cycle |
| hub_req_valid | output | 1 | One-cycle hub request pulse |
| hub_req_type | output | 2 | Hub cycle kind: 00 shutdown, 01 halt, 10 stop-grant |
| hub_abort | input | 1 | Hub master-abort termination pulse |
| sys_mode | output | 1 | System-management-mode flag |
| sys_access | output | 1 | Current request targets system-management space |
| rsvd_err | output | 1 | Sticky reserved-type error |

## Verification
The assertions assume that `hub_abort` is a single-cycle pulse. They also assume that a presented request counts as accepted only in a cycle where `txn_ready` is high. The stimulus drives every request for exactly one cycle and then withdraws it. It gives a held-off request no credit for acceptance. It pulses the abort only once per forwarded cycle, except in the one deliberate case where an abort arrives while nothing is outstanding.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam logic [4:0] P1_SPECIAL    = 5'b01000;
  localparam logic [2:0] P2_SPECIAL_LO = 3'b001;

  typedef enum logic [1:0] {
    ACT_LOCAL   = 2'd0,
    ACT_FWD     = 2'd1,
    ACT_SYSMGMT = 2'd2,
    ACT_RSVD    = 2'd3
  } act_e;

  localparam logic [1:0] HUB_SHUTDOWN  = 2'b00;
  localparam logic [1:0] HUB_HALT      = 2'b01;
  localparam logic [1:0] HUB_STOPGRANT = 2'b10;

  typedef struct packed {
    logic       special;
    act_e       act;
    logic [1:0] hub_code;
  } dec_t;
endpackage

// File: rtl/spc_decode.sv
module spc_decode import spc_pkg::*; #(
  parameter int REQ_W = 5,
  parameter int BE_W  = 8
) (
  input  logic [REQ_W-1:0] code_p1,
  input  logic [REQ_W-1:0] code_p2,
  input  logic [BE_W-1:0]  be_p2,
  output dec_t             dec
);
  localparam int LO_W = 3;

  logic unused_hi;
  assign unused_hi = &{1'b0, code_p2[REQ_W-1:LO_W]};

  always_comb begin
    dec          = '0;
    dec.act      = ACT_RSVD;
    dec.hub_code = HUB_SHUTDOWN;
    dec.special  = (code_p1 == P1_SPECIAL) && (code_p2[LO_W-1:0] == P2_SPECIAL_LO);
    case (be_p2)
      BE_W'(0), BE_W'(2), BE_W'(4), BE_W'(5): dec.act = ACT_LOCAL;
      BE_W'(1): begin dec.act = ACT_FWD; dec.hub_code = HUB_SHUTDOWN;  end
      BE_W'(3): begin dec.act = ACT_FWD; dec.hub_code = HUB_HALT;      end
      BE_W'(6): begin dec.act = ACT_FWD; dec.hub_code = HUB_STOPGRANT; end
      BE_W'(7): dec.act = ACT_SYSMGMT;
      default:  dec.act = ACT_RSVD;
    endcase
  end

  // R1: a request flagged as special carries the first-phase special code
  always_comb begin
    if (dec.special) begin
      p_special_code_r1: assert (code_p1 == P1_SPECIAL);
    end
  end
endmodule

// File: rtl/spc_fwd_ctrl.sv
module spc_fwd_ctrl import spc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  act_e       act,
  input  logic [1:0] hub_code,
  input  logic       hub_abort,
  output logic       busy,
  output logic       retire,
  output logic       hub_req_valid,
  output logic [1:0] hub_req_type
);
  logic       busy_q, busy_d;
  logic       retire_q, retire_d;
  logic       hubv_q, hubv_d;
  logic [1:0] htype_q;
  logic       htype_en;

  always_comb begin
    hubv_d   = accept && (act == ACT_FWD);
    htype_en = hubv_d;
    retire_d = (accept && (act != ACT_FWD)) || (busy_q && hub_abort);
    busy_d   = busy_q;
    if (busy_q && hub_abort) busy_d = 1'b0;
    else if (hubv_d)         busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      retire_q <= 1'b0;
      hubv_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      retire_q <= retire_d;
      hubv_q   <= hubv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        htype_q <= HUB_SHUTDOWN;
    else if (htype_en) htype_q <= hub_code;
  end

  assign busy          = busy_q;
  assign retire        = retire_q;
  assign hub_req_valid = hubv_q;
  assign hub_req_type  = htype_q;

  p_hub_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hub_req_valid |=> !hub_req_valid);
  p_fwd_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act == ACT_FWD) |=> (busy && hub_req_valid));
  p_retire_after_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hub_abort) |=> retire);
  p_no_early_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hub_abort) |=> !retire);
  p_idle_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> !retire);
endmodule

// File: rtl/spc_sysmgmt.sv
module spc_sysmgmt import spc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic txn_valid,
  input  logic accept,
  input  act_e act,
  input  logic addr_b7,
  output logic sys_mode,
  output logic sys_access,
  output logic rsvd_err
);
  logic mode_q, mode_d, mode_en;
  logic err_q, err_d, err_en;

  always_comb begin
    mode_en = accept && (act == ACT_SYSMGMT);
    mode_d  = addr_b7;
    err_en  = accept && (act == ACT_RSVD);
    err_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign sys_mode   = mode_q;
  assign sys_access = txn_valid && mode_q && addr_b7;
  assign rsvd_err   = err_q;

  p_mode_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act == ACT_SYSMGMT && addr_b7) |=> sys_mode);
  p_mode_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && act == ACT_SYSMGMT && !addr_b7) |=> !sys_mode);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_err |=> rsvd_err);
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && act == ACT_SYSMGMT) |=> $stable(sys_mode));
endmodule

// File: rtl/spc_dispatch.sv
module spc_dispatch import spc_pkg::*; #(
  parameter int REQ_W = 5,
  parameter int BE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_valid,
  input  logic [REQ_W-1:0] code_p1,
  input  logic [REQ_W-1:0] code_p2,
  input  logic [BE_W-1:0]  be_p2,
  input  logic             addr_p2_b7,
  output logic             txn_ready,
  output logic             claim,
  output logic             retire,
  output logic             hub_req_valid,
  output logic [1:0]       hub_req_type,
  input  logic             hub_abort,
  output logic             sys_mode,
  output logic             sys_access,
  output logic             rsvd_err
);
  dec_t dec;
  logic busy;
  logic accept;

  spc_decode #(.REQ_W(REQ_W), .BE_W(BE_W)) u_dec (
    .code_p1(code_p1), .code_p2(code_p2), .be_p2(be_p2), .dec(dec)
  );

  assign txn_ready = !(busy && dec.special);
  assign accept    = txn_valid && dec.special && !busy;
  assign claim     = accept;

  spc_fwd_ctrl u_fwd (
    .clk(clk), .rst_n(rst_n), .accept(accept), .act(dec.act),
    .hub_code(dec.hub_code), .hub_abort(hub_abort), .busy(busy),
    .retire(retire), .hub_req_valid(hub_req_valid), .hub_req_type(hub_req_type)
  );

  spc_sysmgmt u_sys (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .accept(accept),
    .act(dec.act), .addr_b7(addr_p2_b7), .sys_mode(sys_mode),
    .sys_access(sys_access), .rsvd_err(rsvd_err)
  );

  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txn_valid && dec.special) |-> (!txn_ready && !claim));
endmodule

// File: tb/sim_spc_dispatch.sv
module sim_spc_dispatch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       txn_valid, addr_p2_b7, hub_abort;
  logic [4:0] code_p1, code_p2;
  logic [7:0] be_p2;
  logic       txn_ready, claim, retire, hub_req_valid, sys_mode, sys_access, rsvd_err;
  logic [1:0] hub_req_type;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  spc_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .code_p1(code_p1),
    .code_p2(code_p2), .be_p2(be_p2), .addr_p2_b7(addr_p2_b7),
    .txn_ready(txn_ready), .claim(claim), .retire(retire),
    .hub_req_valid(hub_req_valid), .hub_req_type(hub_req_type),
    .hub_abort(hub_abort), .sys_mode(sys_mode), .sys_access(sys_access),
    .rsvd_err(rsvd_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    txn_valid = 0; code_p1 = 5'b0; code_p2 = 5'b0; be_p2 = 8'h0;
    addr_p2_b7 = 0; hub_abort = 0;
  endtask

  // Presents one request for a cycle; returns claim and ready seen in that cycle.
  // On return the clock is at the following negedge with the request withdrawn.
  task automatic present(input logic [4:0] c1, input logic [4:0] c2, input logic [7:0] be,
                         input logic b7, output logic cl, output logic rd);
    @(negedge clk);
    txn_valid = 1; code_p1 = c1; code_p2 = c2; be_p2 = be; addr_p2_b7 = b7;
    #1; cl = claim; rd = txn_ready;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R11 sys_mode", sys_mode, 0);
    chk("R11 rsvd_err", rsvd_err, 0);
    chk("R11 ready", txn_ready, 1);
    chk("R11 retire", retire, 0);
    chk("R11 hub_req", hub_req_valid, 0);
  endtask

  task automatic t_local(input logic [7:0] be, input logic [4:0] c2);
    logic cl, rd;
    present(5'b01000, c2, be, 0, cl, rd);
    chk("R1 claim", cl, 1);
    chk("R2 retire next cycle", retire, 1);
    chk("R2 no hub req", hub_req_valid, 0);
    @(negedge clk);
    chk("R2 retire one pulse", retire, 0);
  endtask

  task automatic t_forward(input logic [7:0] be, input logic [1:0] code);
    logic cl, rd;
    present(5'b01000, 5'b00001, be, 0, cl, rd);
    chk("R3 claim", cl, 1);
    chk("R3 hub_req_valid", hub_req_valid, 1);
    chk("R3 hub_req_type", hub_req_type, code);
    chk("R4 no retire yet", retire, 0);
    @(negedge clk);
    chk("R3 hub pulse one cycle", hub_req_valid, 0);
    @(negedge clk);
    chk("R4 still waiting", retire, 0);
    hub_abort = 1;
    @(negedge clk);
    hub_abort = 0;
    chk("R4 retire after abort", retire, 1);
    chk("R5 ready back", txn_ready, 1);
    @(negedge clk);
    chk("R4 retire one pulse", retire, 0);
  endtask

  task automatic t_busy();
    logic cl, rd;
    present(5'b01000, 5'b00001, 8'h03, 0, cl, rd);
    chk("R3 halt type", hub_req_type, 2'b01);
    present(5'b01000, 5'b00001, 8'h02, 0, cl, rd);
    chk("R5 not ready", rd, 0);
    chk("R5 no claim", cl, 0);
    chk("R5 no retire", retire, 0);
    present(5'b01000, 5'b00001, 8'h07, 1, cl, rd);
    chk("R5 held SMI no effect", sys_mode, 0);
    hub_abort = 1;
    @(negedge clk);
    hub_abort = 0;
    chk("R4 retire", retire, 1);
    @(negedge clk);
  endtask

  task automatic t_sysmgmt();
    logic cl, rd;
    @(negedge clk);
    txn_valid = 1; code_p1 = 5'b00110; code_p2 = 5'b00010; addr_p2_b7 = 1;
    #1; chk("R8 no tag before entry", sys_access, 0);
    idle();
    present(5'b01000, 5'b00001, 8'h07, 1, cl, rd);
    chk("R6 claim", cl, 1);
    chk("R6 mode set", sys_mode, 1);
    chk("R6 retire", retire, 1);
    chk("R6 no hub", hub_req_valid, 0);
    @(negedge clk);
    txn_valid = 1; code_p1 = 5'b00110; code_p2 = 5'b00010; addr_p2_b7 = 1;
    #1; chk("R8 tag with b7", sys_access, 1);
    addr_p2_b7 = 0;
    #1; chk("R8 no tag without b7", sys_access, 0);
    txn_valid = 0; addr_p2_b7 = 1;
    #1; chk("R8 no tag when idle", sys_access, 0);
    idle();
    present(5'b01000, 5'b00001, 8'h07, 0, cl, rd);
    chk("R7 mode cleared", sys_mode, 0);
    chk("R7 retire", retire, 1);
    chk("R7 no hub", hub_req_valid, 0);
  endtask

  task automatic t_reserved();
    logic cl, rd;
    present(5'b01000, 5'b00001, 8'h07, 1, cl, rd);
    present(5'b01000, 5'b00001, 8'h08, 0, cl, rd);
    chk("R9 claim", cl, 1);
    chk("R9 retire", retire, 1);
    chk("R9 err set", rsvd_err, 1);
    chk("R9 no hub", hub_req_valid, 0);
    chk("R9 mode kept", sys_mode, 1);
    present(5'b01000, 5'b00001, 8'h00, 0, cl, rd);
    chk("R9 err sticky", rsvd_err, 1);
    present(5'b01000, 5'b00001, 8'hFF, 0, cl, rd);
    chk("R9 top value retire", retire, 1);
  endtask

  task automatic t_non_special();
    logic cl, rd;
    present(5'b01001, 5'b00001, 8'h07, 0, cl, rd);
    chk("R10 bad p1 no claim", cl, 0);
    chk("R10 no retire", retire, 0);
    chk("R10 mode kept", sys_mode, 1);
    present(5'b01000, 5'b00011, 8'h01, 0, cl, rd);
    chk("R10 bad p2 no claim", cl, 0);
    chk("R10 no hub", hub_req_valid, 0);
    chk("R10 no retire 2", retire, 0);
  endtask

  task automatic t_idle_abort();
    @(negedge clk);
    hub_abort = 1;
    @(negedge clk);
    hub_abort = 0;
    chk("R12 no retire", retire, 0);
    chk("R12 ready", txn_ready, 1);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_local(8'h00, 5'b00001);
    t_local(8'h02, 5'b11001);
    t_local(8'h04, 5'b10001);
    t_local(8'h05, 5'b01001);
    t_forward(8'h01, 2'b00);
    t_forward(8'h03, 2'b01);
    t_forward(8'h06, 2'b10);
    t_busy();
    t_sysmgmt();
    t_reserved();
    t_non_special();
    t_idle_abort();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule